// File: doc/BRIEF.md
# Predicated Four-Way Interleaving Store Unit

This block writes four equal-length source vectors to memory as an array of four-member structures. The structure for element index i holds vector 0, vector 1, vector 2 and vector 3 at that index, in that order. Every member is 64 bits wide. The vector length is a parameter between 128 and 2048 bits, so one vector holds between 2 and 32 elements. The block computes the start address from a scalar base and a scalar index; the index counts 64-bit units.

A one-cycle start pulse captures the operands. The block then walks the element indices upward. For each index whose predicate bit is set, it issues four 64-bit writes on a valid/ready memory port. An index with a clear predicate bit produces no traffic, cannot fault, and leaves its memory untouched. At the end the block emits a one-cycle done pulse. If the memory signals a fault, the block stops and emits a fault pulse that carries the element index.

Top module: `quad_store_unit`

## Requirements
- R1: The first structure begins at base + (index << 3), computed modulo 2^ADDR_W.
- R2: For each active element, exactly four writes are issued, carrying vector 0, 1, 2 and 3 at that element in that order. Elements are visited in increasing index order.
- R3: Member k of element i is written at start + 32*i + 8*k.
- R4: The predicate input has one bit per vector byte. Bit 8*i governs element i, and every other bit of the predicate is ignored.
- R5: An element whose governing predicate bit is 0 produces no write.
- R6: A write completes only in a cycle where mem_valid and mem_ready are both high. While mem_valid is high and mem_ready is low, mem_addr and mem_data hold their values.
- R7: When mem_fault is high during a completing write, fault pulses for one cycle in the next cycle, fault_elem gives that write's element index, and no further write is issued.
- R8: If no element is active, done is high in the cycle after start, and no write is issued.
- R9: done is a one-cycle pulse in the cycle after the last write completes, and mem_valid is low while done is high.
- R10: A start pulse that arrives while an operation is running is ignored.
- R11: After reset, mem_valid, done and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when idle |
| base_addr | input | ADDR_W | Scalar base address |
| index_reg | input | ADDR_W | Scalar index in 64-bit units |
| src0 | input | VL_BITS | Source vector for member 0 |
| src1 | input | VL_BITS | Source vector for member 1 |
| src2 | input | VL_BITS | Source vector for member 2 |
| src3 | input | VL_BITS | Source vector for member 3 |
| pred | input | VL_BITS/8 | Byte-granular predicate |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 64 | Write data |
| mem_fault | input | 1 | Fault response for the completing write |
| done | output | 1 | Operation finished pulse |
| fault | output | 1 | Operation aborted pulse |
| fault_elem | output | IDX_W | Element index of the faulting write |

## Verification
The hardest case to reach is a fault in the middle of a structure after some elements were skipped. The write count is then cut short partway through an element, and fault_elem must name that element and not a position in the write stream. The bench injects the fault at a chosen handshake number. The scoreboard queue is trimmed to the same point, so a stray write after the fault is reported as an unexpected item. A throttled ready pattern holds requests pending for stability checks. A second start pulse, sent while the unit is busy and carrying an empty predicate, shows up as an early done if the unit accepts it.

// File: rtl/qsu_pkg.sv
package qsu_pkg;
    localparam int ELEM_W       = 64;
    localparam int MEMBERS      = 4;
    localparam int MEMBER_SHIFT = 3;   // 8 bytes per member
    localparam int STRUCT_SHIFT = 5;   // 32 bytes per structure
    localparam int INDEX_SHIFT  = 3;   // scalar index counts 64-bit units

    typedef enum logic [0:0] {QS_IDLE, QS_RUN} qs_state_e;

    typedef logic [1:0] member_t;

    function automatic bit is_last_member(member_t m);
        return m == member_t'(MEMBERS - 1);
    endfunction
endpackage

// File: rtl/qsu_next_active.sv
module qsu_next_active #(
    parameter int NELEM = 4,
    parameter int IDX_W = 2
) (
    input  logic [NELEM-1:0] mask,
    input  logic [IDX_W:0]   from_idx,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (mask[i] && ((IDX_W+1)'(i) >= from_idx)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/qsu_addr_gen.sv
module qsu_addr_gen
    import qsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] index_reg,
    input  logic [ADDR_W-1:0] start_q,
    input  logic [IDX_W-1:0]  elem,
    input  member_t           member,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] wr_addr
);
    assign start_addr = base_addr + (index_reg << INDEX_SHIFT);
    assign wr_addr    = start_q
                      + (ADDR_W'(elem)   << STRUCT_SHIFT)
                      + (ADDR_W'(member) << MEMBER_SHIFT);
endmodule

// File: rtl/qsu_lane_sel.sv
module qsu_lane_sel
    import qsu_pkg::*;
#(
    parameter int VL_BITS = 256,
    parameter int IDX_W   = 2
) (
    input  logic [MEMBERS*VL_BITS-1:0] vecs,
    input  logic [IDX_W-1:0]           elem,
    input  member_t                    member,
    output logic [ELEM_W-1:0]          lane
);
    always_comb begin
        lane = vecs[int'(member)*VL_BITS + int'(elem)*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/quad_store_unit.sv
module quad_store_unit
    import qsu_pkg::*;
#(
    parameter int VL_BITS = 256,
    parameter int ADDR_W  = 32,
    localparam int NELEM  = VL_BITS / ELEM_W,
    localparam int PRED_W = VL_BITS / 8,
    localparam int IDX_W  = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [ADDR_W-1:0]   index_reg,
    input  logic [VL_BITS-1:0]  src0,
    input  logic [VL_BITS-1:0]  src1,
    input  logic [VL_BITS-1:0]  src2,
    input  logic [VL_BITS-1:0]  src3,
    input  logic [PRED_W-1:0]   pred,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ELEM_W-1:0]   mem_data,
    input  logic                mem_fault,
    output logic                done,
    output logic                fault,
    output logic [IDX_W-1:0]    fault_elem
);
    qs_state_e                  state_q;
    logic [IDX_W-1:0]           elem_q;
    member_t                    member_q;
    logic [ADDR_W-1:0]          start_q;
    logic [MEMBERS*VL_BITS-1:0] src_q;
    logic [NELEM-1:0]           mask_q;
    logic [NELEM-1:0]           in_mask;
    logic [NELEM-1:0]           scan_mask;
    logic [IDX_W:0]             scan_from;
    logic                       scan_found;
    logic [IDX_W-1:0]           scan_idx;
    logic [ADDR_W-1:0]          start_addr;
    logic                       handshake;

    // Governing predicate bit per element: the lowest bit of its byte group
    for (genvar g = 0; g < NELEM; g++) begin : g_mask
        assign in_mask[g] = pred[g*8];
    end

    assign scan_mask = (state_q == QS_IDLE) ? in_mask : mask_q;
    assign scan_from = (state_q == QS_IDLE) ? '0
                     : (IDX_W+1)'(elem_q) + (IDX_W+1)'(1);

    qsu_next_active #(.NELEM(NELEM), .IDX_W(IDX_W)) u_scan (
        .mask(scan_mask), .from_idx(scan_from),
        .found(scan_found), .idx(scan_idx)
    );

    qsu_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base_addr(base_addr), .index_reg(index_reg), .start_q(start_q),
        .elem(elem_q), .member(member_q),
        .start_addr(start_addr), .wr_addr(mem_addr)
    );

    qsu_lane_sel #(.VL_BITS(VL_BITS), .IDX_W(IDX_W)) u_lane (
        .vecs(src_q), .elem(elem_q), .member(member_q), .lane(mem_data)
    );

    assign mem_valid = (state_q == QS_RUN);
    assign handshake = mem_valid && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= QS_IDLE;
            elem_q     <= '0;
            member_q   <= '0;
            start_q    <= '0;
            src_q      <= '0;
            mask_q     <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_elem <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state_q)
                QS_IDLE: begin
                    if (start) begin
                        start_q  <= start_addr;
                        src_q    <= {src3, src2, src1, src0};
                        mask_q   <= in_mask;
                        member_q <= '0;
                        elem_q   <= scan_idx;
                        if (scan_found) state_q <= QS_RUN;
                        else            done    <= 1'b1;
                    end
                end
                QS_RUN: begin
                    if (handshake) begin
                        if (mem_fault) begin
                            fault      <= 1'b1;
                            fault_elem <= elem_q;
                            state_q    <= QS_IDLE;
                        end else if (is_last_member(member_q)) begin
                            member_q <= '0;
                            if (scan_found) begin
                                elem_q <= scan_idx;
                            end else begin
                                done    <= 1'b1;
                                state_q <= QS_IDLE;
                            end
                        end else begin
                            member_q <= member_q + member_t'(1);
                        end
                    end
                end
                default: state_q <= QS_IDLE;
            endcase
        end
    end

    // R6
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R5
    active_elem_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> mask_q[elem_q]);

    // R7
    fault_follows_resp_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> ($past(mem_valid && mem_ready && mem_fault) && !mem_valid));

    // R9
    done_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_valid && !fault));
endmodule

// File: tb/quad_store_unit_tb.sv
module quad_store_unit_tb;
    localparam int VL  = 256;
    localparam int AW  = 32;
    localparam int NE  = VL / 64;
    localparam int PW  = VL / 8;
    localparam int IW  = $clog2(NE);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [63:0]   data;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW-1:0] index_reg = '0;
    logic [VL-1:0] src0 = '0, src1 = '0, src2 = '0, src3 = '0;
    logic [PW-1:0] pred = '0;
    logic mem_valid, mem_ready = 1'b1, mem_fault = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_data;
    logic done, fault;
    logic [IW-1:0] fault_elem;

    quad_store_unit #(.VL_BITS(VL), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .base_addr(base_addr), .index_reg(index_reg),
        .src0(src0), .src1(src1), .src2(src2), .src3(src3), .pred(pred),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_fault(mem_fault),
        .done(done), .fault(fault), .fault_elem(fault_elem)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    int wr_cnt = 0, hs_cnt = 0, fault_at = -1, cyc = 0;
    bit ready_mode = 0, finished = 0;
    wr_item_t exp_q[$];

    task automatic check(bit ok, string req, logic [95:0] act, logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_val(int k, int i, logic [7:0] seed);
        return 64'hC0DE_0000_0000_0000 ^ (64'(k) << 40) ^ (64'(i) << 24) ^ 64'(seed);
    endfunction

    task automatic load_srcs(logic [7:0] seed);
        for (int i = 0; i < NE; i++) begin
            src0[i*64 +: 64] = lane_val(0, i, seed);
            src1[i*64 +: 64] = lane_val(1, i, seed);
            src2[i*64 +: 64] = lane_val(2, i, seed);
            src3[i*64 +: 64] = lane_val(3, i, seed);
        end
    endtask

    // Driver: computes the expected write stream and pushes it to the scoreboard.
    // Returns the element of the faulting write, or -1 when done is expected.
    task automatic push_op(logic [AW-1:0] b, logic [AW-1:0] x, logic [PW-1:0] p,
                           logic [7:0] seed, int f_at, output int f_elem);
        logic [AW-1:0] st;
        int n;
        st = b + (x << 3);
        n = 0;
        f_elem = -1;
        base_addr = b; index_reg = x; pred = p; load_srcs(seed);
        fault_at = f_at; hs_cnt = 0; wr_cnt = 0;
        for (int i = 0; i < NE; i++) begin
            if (p[8*i]) begin
                for (int k = 0; k < 4; k++) begin
                    if (f_at < 0 || n <= f_at) begin
                        exp_q.push_back('{addr: st + AW'(32*i) + AW'(8*k),
                                          data: lane_val(k, i, seed)});
                        if (n == f_at) f_elem = i;
                    end
                    n++;
                end
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_fault, output int fe);
        got_done = 0; got_fault = 0; fe = -1;
        for (int t = 0; t < 2000; t++) begin
            if (done || fault) begin
                got_done = done; got_fault = fault; fe = int'(fault_elem);
                break;
            end
            @(negedge clk);
        end
    endtask

    // Ready generator, changes just after each rising edge
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            mem_ready = ready_mode ? (cyc % 3 != 0) : 1'b1;
        end
    end

    // Monitor: pops expected writes and compares them; drives the fault response
    logic [AW-1:0] prev_addr;
    logic [63:0] prev_data;
    bit prev_stall = 0;
    initial begin
        forever begin
            @(negedge clk);
            mem_fault = 1'b0;
            if (!rst) begin
                if (prev_stall) begin
                    // R6
                    check(mem_valid && mem_addr == prev_addr && mem_data == prev_data,
                          "R6 hold while stalled", {mem_addr, mem_data}, {prev_addr, prev_data});
                end
                prev_stall = mem_valid && !mem_ready;
                prev_addr = mem_addr; prev_data = mem_data;
                if (mem_valid && mem_ready) begin
                    wr_cnt++;
                    if (exp_q.size() == 0) begin
                        check(0, "R5/R7/R10 unexpected write", {mem_addr, mem_data}, 0);
                    end else begin
                        wr_item_t e;
                        e = exp_q.pop_front();
                        check(mem_addr == e.addr, "R1/R3 address", mem_addr, e.addr);
                        check(mem_data == e.data, "R2 data order", mem_data, e.data);
                    end
                    mem_fault = (hs_cnt == fault_at);
                    hs_cnt++;
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        bit gd, gf;
        int fe, xf;
        repeat (3) @(negedge clk);
        // R11
        check(!mem_valid && !done && !fault, "R11 reset state",
              {mem_valid, done, fault}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Dense predicate, ready always high
        push_op(32'h0000_1000, 32'h3, {PW{1'b1}}, 8'h11, -1, xf);
        pulse_start();
        wait_end(gd, gf, fe);
        check(gd && !gf, "R2 dense op done", {gd, gf}, 2'b10);
        check(wr_cnt == 16, "R2 dense write count", wr_cnt, 16);
        @(negedge clk);
        check(!done, "R9 done single pulse", done, 0);

        // Sparse predicate with noise bits, throttled ready
        ready_mode = 1;
        push_op(32'hFFFF_FFF0, 32'h2, 32'h01FE_FE01, 8'h22, -1, xf);
        pulse_start();
        wait_end(gd, gf, fe);
        check(gd, "R4 sparse op done", gd, 1);
        check(wr_cnt == 8, "R5 skipped elements write count", wr_cnt, 8);
        check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);

        // All elements inactive, noise in other bits
        ready_mode = 0;
        push_op(32'h0000_4000, 32'h0, 32'hFEFE_FEFE, 8'h33, -1, xf);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(done, "R8 done in cycle after start", done, 1);
        check(!mem_valid, "R8 no request", mem_valid, 0);
        @(negedge clk);
        check(!done && wr_cnt == 0, "R8 no writes and single pulse", {done, wr_cnt}, 0);

        // Fault on the sixth write (element 1, member 1)
        ready_mode = 1;
        push_op(32'h0000_8000, 32'h1, {PW{1'b1}}, 8'h44, 5, xf);
        pulse_start();
        wait_end(gd, gf, fe);
        check(gf && !gd, "R7 fault reported", {gd, gf}, 2'b01);
        check(fe == xf, "R7 fault element", fe, xf);
        repeat (10) @(negedge clk);
        check(wr_cnt == 6, "R7 no writes after fault", wr_cnt, 6);

        // Start while busy is ignored (second start carries an empty predicate)
        push_op(32'h0000_2000, 32'h0, 32'h0100_0100, 8'h55, -1, xf);
        pulse_start();
        repeat (2) @(negedge clk);
        base_addr = 32'h0000_9000; pred = '0; load_srcs(8'h66);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(!done, "R10 no early done", done, 0);
        wait_end(gd, gf, fe);
        check(gd && wr_cnt == 8, "R10 first op completes intact", wr_cnt, 8);
        check(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule